// File: doc/BRIEF.md
# Infrared Return-to-Zero Line Codec

This block sits between a UART's shift registers and its serial pins and converts between plain NRZ bits and the short-pulse line code used by serial infrared links. On the transmit side, every zero bit arriving from the shift register leaves the pin as a low pulse that covers only three of the sixteen oversampling ticks of its bit period. One bits, stop bits and an idle line leave the pin high. On the receive side, a short low pulse from the infrared module is synchronised, checked for a minimum width in clock cycles, and widened back into a low level that lasts a full bit period before it reaches the receive shift register.

Both directions are timed by a single-cycle enable, `tick16`, pulsing sixteen times per bit. A mode input selects between this coding and a transparent path in which the pins and shift-register signals are joined directly. Baud generation, character framing and the optical module lie outside the block.

The transmit side is a three-state machine. `TX_IDLE` goes to `TX_PULSE` on a tick that sees a low input. `TX_PULSE` goes to `TX_GAP` after three ticks. At the sixteenth tick of the slot, `TX_GAP` goes back to `TX_PULSE` if the input is still low, and to `TX_IDLE` if it is not. The receive side has four states. `RX_IDLE` goes to `RX_QUAL` on a low synchronised input. `RX_QUAL` goes to `RX_HOLD` once the input has been low for the minimum width, and back to `RX_IDLE` if the input rises before that. `RX_HOLD` runs for sixteen ticks. When those ticks end, it goes to `RX_REQUAL` if the input is low again, and to `RX_IDLE` if it is not. `RX_REQUAL` keeps the output low while it checks the new pulse. It goes to `RX_HOLD` if the pulse is wide enough, and to `RX_IDLE` if it is not. Clearing the mode input sends both machines to their idle states.

Top module: `irda_sir_codec`

## Requirements
- R1: With `ir_en` high and the transmit machine idle, a tick edge that samples `tx_nrz` low starts a bit slot, and `ir_tx` goes low in the cycle right after that edge.
- R2: A transmit pulse keeps `ir_tx` low for exactly 3 tick periods and then high for the other 13 ticks of the 16-tick slot, so every zero bit gives exactly one falling edge on `ir_tx`.
- R3: At the 16th tick of a slot, a `tx_nrz` that is still low starts the next pulse at once, so a run of N zero bits gives N pulses spaced 16 ticks apart. A high `tx_nrz` returns the machine to idle, and `ir_tx` stays high for as long as `tx_nrz` stays high.
- R4: `ir_rx` passes through a 2-flop synchroniser. A low at the synchroniser output is accepted only after 3 consecutive clock cycles. A shorter low never drives `rx_nrz` low.
- R5: With default parameters, an accepted pulse drives `rx_nrz` low 5 clock edges after the edge at which `ir_rx` first samples low. `rx_nrz` then stays low up to and including the 16th tick edge counted after acceptance, and rises after that edge.
- R6: If the synchronised input is low when the hold window ends, `rx_nrz` stays low while that new low is checked. If the new low is accepted, a fresh 16-tick window starts. If the input rises before 3 cycles, `rx_nrz` goes high in the cycle after that rise is seen.
- R7: With `ir_en` low, `ir_tx` equals `tx_nrz` and `rx_nrz` equals `ir_rx` in the same cycle, and both machines return to idle at the next clock edge.
- R8: While `rst_n` is low and `ir_en` is high, `ir_tx` and `rx_nrz` are both high, whatever the levels of `tx_nrz` and `ir_rx`.
- R9: Pulse widths and windows are counted in ticks and not in clock cycles. With `ir_en` held high, `ir_tx` only changes on a clock edge at which `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| ir_en | input | 1 | 1 = pulse coding, 0 = transparent path |
| tx_nrz | input | 1 | NRZ data from the transmit shift register |
| ir_rx | input | 1 | Receive pin from the infrared module |
| ir_tx | output | 1 | Transmit pin to the infrared module |
| rx_nrz | output | 1 | Restored NRZ data to the receive shift register |

## Verification
Framed characters drawn at random, together with all-zero and all-one characters, are sent on the transmit side. The all-zero character shows whether back-to-back slots chain correctly, and the all-one character shows whether one bits leave the line untouched. With the transmit pin looped back to the receive pin, the same characters show whether the restored low level covers whole bits without gaps between consecutive zeros. Directed lows of one, two and three cycles separate rejected glitches from the narrowest accepted pulse. Single-cycle lows placed around the end of a window exercise an aborted requalification. A slower tick rate shows that widths follow ticks and not clocks, and random toggling of the mode input shows the transparent path and the return to idle.

// File: rtl/irda_pkg.sv
package irda_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PULSE,
        TX_GAP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_QUAL,
        RX_HOLD,
        RX_REQUAL
    } rx_state_e;

endpackage

// File: rtl/irda_sync.sv
// Multi-stage synchroniser for the asynchronous receive pin; resets to the
// idle (high) line level.
module irda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/irda_tx_mod.sv
// Transmit side: one short low pulse at the head of every zero-bit slot.
module irda_tx_mod
    import irda_pkg::*;
#(
    parameter int TICKS = 16,
    parameter int PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic nrz_in,
    output logic pulse_low,
    output logic idle_o
);

    localparam int PW = $clog2(TICKS);
    localparam logic [PW-1:0] LAST_PH  = PW'(TICKS - 1);
    localparam logic [PW-1:0] PULSE_PH = PW'(PULSE - 1);

    tx_state_e     st, st_nx;
    logic [PW-1:0] ph, ph_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_IDLE;
            ph <= '0;
        end else begin
            st <= st_nx;
            ph <= ph_nx;
        end
    end

    // transitions, evaluated only on ticks
    always_comb begin
        st_nx = st;
        ph_nx = ph;
        if (!en) begin
            st_nx = TX_IDLE;
            ph_nx = '0;
        end else if (tick) begin
            unique case (st)
                TX_IDLE: begin
                    if (!nrz_in) begin
                        st_nx = TX_PULSE;
                        ph_nx = '0;
                    end
                end
                TX_PULSE: begin
                    ph_nx = ph + PW'(1);
                    if (ph == PULSE_PH) st_nx = TX_GAP;
                end
                TX_GAP: begin
                    if (ph == LAST_PH) begin
                        ph_nx = '0;
                        st_nx = nrz_in ? TX_IDLE : TX_PULSE;
                    end else begin
                        ph_nx = ph + PW'(1);
                    end
                end
                default: begin
                    st_nx = TX_IDLE;
                    ph_nx = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_low = (st == TX_PULSE);
        idle_o    = (st == TX_IDLE);
    end

endmodule

// File: rtl/irda_rx_demod.sv
// Receive side: qualify a short low pulse by width, then hold a low level
// for one tick window counted from acceptance. MIN_LOW must be 2 or more.
module irda_rx_demod
    import irda_pkg::*;
#(
    parameter int TICKS   = 16,
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic rx_s,
    output logic hold_low,
    output logic idle_o
);

    localparam int PW = $clog2(TICKS);
    localparam int QW = $clog2(MIN_LOW + 1);
    localparam logic [PW-1:0] LAST_TICK = PW'(TICKS - 1);
    localparam logic [QW-1:0] QUAL_END  = QW'(MIN_LOW - 1);

    rx_state_e     st, st_nx;
    logic [QW-1:0] qc, qc_nx;
    logic [PW-1:0] tc, tc_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_IDLE;
            qc <= '0;
            tc <= '0;
        end else begin
            st <= st_nx;
            qc <= qc_nx;
            tc <= tc_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        qc_nx = qc;
        tc_nx = tc;
        if (!en) begin
            st_nx = RX_IDLE;
            qc_nx = '0;
            tc_nx = '0;
        end else begin
            unique case (st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        st_nx = RX_QUAL;
                        qc_nx = QW'(1);
                    end
                end
                RX_QUAL, RX_REQUAL: begin
                    if (rx_s) begin
                        st_nx = RX_IDLE;
                    end else if (qc == QUAL_END) begin
                        st_nx = RX_HOLD;
                        tc_nx = '0;
                    end else begin
                        qc_nx = qc + QW'(1);
                    end
                end
                RX_HOLD: begin
                    if (tick) begin
                        if (tc == LAST_TICK) begin
                            if (!rx_s) begin
                                st_nx = RX_REQUAL;
                                qc_nx = QW'(1);
                            end else begin
                                st_nx = RX_IDLE;
                            end
                        end else begin
                            tc_nx = tc + PW'(1);
                        end
                    end
                end
                default: st_nx = RX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        hold_low = (st == RX_HOLD) || (st == RX_REQUAL);
        idle_o   = (st == RX_IDLE);
    end

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int MIN_LOW_CLKS  = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic ir_en,
    input  logic tx_nrz,
    input  logic ir_rx,
    output logic ir_tx,
    output logic rx_nrz
);

    logic rx_s;
    logic pulse_low;
    logic hold_low;
    logic tx_idle;
    logic rx_idle;

    irda_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_rx),
        .q     (rx_s)
    );

    irda_tx_mod #(
        .TICKS (TICKS_PER_BIT),
        .PULSE (PULSE_TICKS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ir_en),
        .tick      (tick16),
        .nrz_in    (tx_nrz),
        .pulse_low (pulse_low),
        .idle_o    (tx_idle)
    );

    irda_rx_demod #(
        .TICKS   (TICKS_PER_BIT),
        .MIN_LOW (MIN_LOW_CLKS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ir_en),
        .tick     (tick16),
        .rx_s     (rx_s),
        .hold_low (hold_low),
        .idle_o   (rx_idle)
    );

    assign ir_tx  = ir_en ? ~pulse_low : tx_nrz;
    assign rx_nrz = ir_en ? ~hold_low  : ir_rx;

endmodule

// File: rtl/irda_sir_chk.sv
module irda_sir_chk #(
    parameter int PULSE_TICKS  = 3,
    parameter int MIN_LOW_CLKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic ir_en,
    input logic tx_nrz,
    input logic ir_tx,
    input logic rx_nrz,
    input logic rx_s,
    input logic tx_idle,
    input logic rx_idle
);

    logic [7:0] low_ticks;
    logic [7:0] low_run;

    // ticks seen while the coded transmit pin is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_ticks <= '0;
        else if (ir_en && !ir_tx)  low_ticks <= (low_ticks == 8'hFF) ? low_ticks : low_ticks + {7'd0, tick16};
        else                       low_ticks <= '0;
    end

    // consecutive low cycles at the synchroniser output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_run <= '0;
        else if (rx_s)              low_run <= '0;
        else if (low_run != 8'hFF)  low_run <= low_run + 8'd1;
    end

    // R1: a coded falling edge needs a tick that saw a zero
    a_r1_fall_needs_zero_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $fell(ir_tx)) |-> ($past(tick16) && !$past(tx_nrz)));

    // R2: a pulse never spans more than its tick count
    a_r2_pulse_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= 8'(PULSE_TICKS));

    // R4: rx output falls only after the minimum low run
    a_r4_accept_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $fell(rx_nrz)) |-> (low_run >= 8'(MIN_LOW_CLKS)));

    // R7: disabling returns both machines to idle
    a_r7_off_resets_fsms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ir_en) |-> (tx_idle && rx_idle));

    // R9: the coded transmit pin only moves on ticks
    a_r9_tx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && !$past(tick16)) |-> $stable(ir_tx));

endmodule

bind irda_sir_codec irda_sir_chk #(
    .PULSE_TICKS  (PULSE_TICKS),
    .MIN_LOW_CLKS (MIN_LOW_CLKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick16  (tick16),
    .ir_en   (ir_en),
    .tx_nrz  (tx_nrz),
    .ir_tx   (ir_tx),
    .rx_nrz  (rx_nrz),
    .rx_s    (rx_s),
    .tx_idle (tx_idle),
    .rx_idle (rx_idle)
);

// File: tb/sim_irda_sir_codec.sv
`timescale 1ns/1ps
module sim_irda_sir_codec;

    localparam int TPB = 16;
    localparam int PLS = 3;
    localparam int MLW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic ir_en = 1'b1;
    logic tx_nrz = 1'b0;
    logic rx_stim = 1'b1;
    logic loop_mode = 1'b0;
    logic lb_q = 1'b1;
    logic ir_rx;
    logic ir_tx;
    logic rx_nrz;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int div_n = 4;
    int tdiv = 0;
    bit done = 0;
    bit started = 0;

    string tag_tx = "R8";
    string tag_rx = "R8";

    // bench reference state
    bit m_act; int m_ph;
    bit m_s1, m_s2;
    int m_mode; int m_run; int m_win;
    logic prev_tx = 1'b1;
    int tx_falls = 0;
    int rx_low_cnt = 0;
    int rx_cur_run = 0;
    int rx_max_run = 0;

    always #10 clk = ~clk;

    assign ir_rx = loop_mode ? lb_q : rx_stim;

    irda_sir_codec u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick16 (tick16),
        .ir_en  (ir_en),
        .tx_nrz (tx_nrz),
        .ir_rx  (ir_rx),
        .ir_tx  (ir_tx),
        .rx_nrz (rx_nrz)
    );

    always @(negedge clk) begin
        lb_q <= ir_tx;
        tdiv = (tdiv + 1 >= div_n) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 0);
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic chk_int(input string tag, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", tag, what, act, lo, hi);
        end
    endtask

    // reference step for the edge just passed, then compare
    always @(posedge clk) begin
        logic rs, e_tx, e_rx;
        cyc++;
        #5;
        if (!rst_n) begin
            m_act = 0; m_ph = 0; m_s1 = 1; m_s2 = 1; m_mode = 0; m_run = 0; m_win = 0;
        end else begin
            rs = m_s2;
            m_s2 = m_s1;
            m_s1 = ir_rx;
            if (!ir_en) m_act = 0;
            else if (tick16) begin
                if (!m_act) begin
                    if (!tx_nrz) begin m_act = 1; m_ph = 0; end
                end else begin
                    m_ph++;
                    if (m_ph == TPB) begin
                        if (!tx_nrz) m_ph = 0; else m_act = 0;
                    end
                end
            end
            if (!ir_en) m_mode = 0;
            else if (m_mode == 0) begin
                if (!rs) begin m_mode = 1; m_run = 1; end
            end else if (m_mode == 1 || m_mode == 3) begin
                if (rs) m_mode = 0;
                else if (m_run >= MLW - 1) begin m_mode = 2; m_win = 0; end
                else m_run++;
            end else if (tick16) begin
                if (m_win == TPB - 1) begin
                    if (!rs) begin m_mode = 3; m_run = 1; end else m_mode = 0;
                end else m_win++;
            end
        end
        e_tx = ir_en ? !(m_act && m_ph < PLS) : tx_nrz;
        e_rx = ir_en ? !(m_mode == 2 || m_mode == 3) : ir_rx;
        chk(tag_tx, "ir_tx", ir_tx, e_tx);
        chk(tag_rx, "rx_nrz", rx_nrz, e_rx);
        if (ir_en && prev_tx === 1'b1 && ir_tx === 1'b0) tx_falls++;
        prev_tx = ir_tx;
        if (rx_nrz === 1'b0) begin
            rx_low_cnt++; rx_cur_run++;
            if (rx_cur_run > rx_max_run) rx_max_run = rx_cur_run;
        end else rx_cur_run = 0;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        tx_nrz = b;
        wait_cyc(TPB * div_n);
    endtask

    task automatic send_frame(input logic [7:0] d);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(1'b1);
    endtask

    function automatic int zeros_in_frame(input logic [7:0] d);
        int z = 1;
        for (int i = 0; i < 8; i++) if (!d[i]) z++;
        return z;
    endfunction

    task automatic rx_pulse(input int width, input int gap);
        rx_stim = 1'b0;
        wait_cyc(width);
        rx_stim = 1'b1;
        wait_cyc(gap);
    endtask

    task automatic frame_check(input string tag, input logic [7:0] d);
        tx_falls = 0;
        send_frame(d);
        wait_cyc(4);
        chk_int(tag, "falls per frame", tx_falls, zeros_in_frame(d), zeros_in_frame(d));
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd51966));
        // R8: reset with coding on and both inputs low
        tx_nrz = 1'b0; rx_stim = 1'b0; ir_en = 1'b1;
        wait_cyc(3);
        chk("R8", "ir_tx in reset", ir_tx, 1'b1);
        chk("R8", "rx_nrz in reset", rx_nrz, 1'b1);
        tx_nrz = 1'b1; rx_stim = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(20);

        // R1: a single zero bit
        tag_tx = "R1"; tag_rx = "R1";
        tx_falls = 0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        chk_int("R1", "one zero bit falls", tx_falls, 1, 1);
        frame_check("R1", 8'hFF);

        // R3: consecutive zeros and long high
        tag_tx = "R3";
        frame_check("R3", 8'h00);
        tx_falls = 0;
        wait_cyc(300);
        chk_int("R3", "idle line falls", tx_falls, 0, 0);

        // R2: random frames
        tag_tx = "R2"; tag_rx = "R2";
        for (int k = 0; k < 10; k++) frame_check("R2", 8'($urandom_range(0, 255)));

        // R4: glitches of 1 and 2 cycles
        tag_tx = "R4"; tag_rx = "R4";
        rx_low_cnt = 0;
        rx_pulse(1, 20); rx_pulse(2, 20); rx_pulse(1, 1); rx_pulse(2, 20);
        chk_int("R4", "rx low cycles after glitches", rx_low_cnt, 0, 0);

        // R5: narrowest accepted pulse, window length
        tag_rx = "R5";
        rx_low_cnt = 0;
        rx_pulse(3, 120);
        chk_int("R5", "rx low cycles for one pulse", rx_low_cnt, TPB * 4 - 3, TPB * 4);
        rx_low_cnt = 0;
        rx_pulse(12, 120);
        chk_int("R5", "rx low cycles for wide pulse", rx_low_cnt, TPB * 4 - 3, TPB * 4);

        // R6: loopback of all-zero frame, then glitches at window end
        tag_tx = "R6"; tag_rx = "R6";
        loop_mode = 1'b1;
        rx_max_run = 0;
        frame_check("R6", 8'h00);
        chk_int("R6", "continuous rx low run", rx_max_run, 9 * 64 - 8, 9 * 64 + 8);
        loop_mode = 1'b1;
        for (int k = 0; k < 6; k++) frame_check("R6", 8'($urandom_range(0, 255)));
        loop_mode = 1'b0;
        for (int off = 56; off < 72; off++) begin
            rx_pulse(4, off);
            rx_pulse(1, 140);
        end

        // R9: slower ticks stretch pulses
        tag_tx = "R9"; tag_rx = "R9";
        div_n = 7;
        wait_cyc(20);
        loop_mode = 1'b1;
        for (int k = 0; k < 4; k++) frame_check("R9", 8'($urandom_range(0, 255)));
        loop_mode = 1'b0;
        div_n = 4;
        wait_cyc(40);

        // R7: random mode toggling with random inputs
        tag_tx = "R7"; tag_rx = "R7";
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 7) == 0) ir_en = ~ir_en;
            tx_nrz = 1'($urandom_range(0, 1));
            rx_stim = 1'($urandom_range(0, 1));
            wait_cyc($urandom_range(1, 20));
        end
        ir_en = 1'b0;
        tx_nrz = 1'b0; rx_stim = 1'b0;
        wait_cyc(2);
        chk("R7", "pass tx", ir_tx, 1'b0);
        chk("R7", "pass rx", rx_nrz, 1'b0);
        ir_en = 1'b1;
        wait_cyc(1);
        chk("R7", "re-enable tx idle", ir_tx, 1'b1);
        tx_nrz = 1'b1; rx_stim = 1'b1;
        wait_cyc(100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule